// File: doc/BRIEF.md
# SMI Status and Assertion Controller

This block holds the 32-bit status register of a system-management-interrupt controller and drives the active-low SMI request line. Nine event sources each pulse a dedicated input. Each pulse latches a sticky status bit, and software clears that bit by writing a 1 to it. A per-source enable vector, supplied from outside, selects which latched bits count as pending.

The interrupt line is governed by an end-of-interrupt handshake bit. The line is driven low when the handshake bit is 1 and an enabled status bit is set. On that same edge the handshake bit clears itself. The line stays low until software writes 1 to the handshake bit.

A separate write-only bit requests a one-cycle SCI pulse. Software reaches the register through a simple address/write-data/read-data port. The register answers at one fixed offset from its I/O base.

Top module: `smi_status_ctrl`

## Requirements
- R1: After reset the register reads 00000000h, `smi_n` is 1 and `sci_pulse` is 0.
- R2: A 1 on `src_evt[i]` at a clock edge sets a sticky status bit, visible on `bus_rdata` after that edge. The bit positions are: index 0 to bit 2 (sleep enable write), 1 to bit 3 (SPI), 2 to bit 4 (APM), 3 to bit 8 (external SMI input), 4 to bit 9 (GPIO), 5 to bit 10 (system error), 6 to bit 15 (device line), 7 to bit 16 (management unit) and 8 to bit 17 (PCIe).
- R3: A write at offset 14h clears every status bit whose data bit is 1. Data bits that are 0 leave the status untouched.
- R4: When a set event and a write-1-to-clear hit the same status bit on the same edge, the bit ends up set.
- R5: Bits 29:18, 14:11, 7:5, 1:0 and bit 30 always read 0, whatever was written.
- R6: A write at offset 14h with data bit 30 set makes `sci_pulse` 1 for exactly the cycle after that edge. Otherwise `sci_pulse` is 0.
- R7: When bit 31 (end-of-interrupt) is 1 and some status bit is set whose `src_en` bit is also 1, the next edge drives `smi_n` to 0 and clears bit 31.
- R8: Once low, `smi_n` stays 0 until a write at offset 14h with data bit 31 set. That write returns `smi_n` to 1 on its edge and sets bit 31.
- R9: Status bits whose `src_en` bit is 0 never drive `smi_n` low.
- R10: Writes at any other offset change nothing, and reads at any other offset return 0.
- R11: Bit 31 resets to 0, so `smi_n` cannot go low before software first writes 1 to bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset within the I/O block |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| src_evt | input | 9 | Event pulses, one per source |
| src_en | input | 9 | Per-source enable for interrupt generation |
| smi_n | output | 1 | Active-low system-management interrupt |
| sci_pulse | output | 1 | One-cycle SCI request |

## Verification
The bench targets a clear and a set landing on the same bit in the same cycle. A design that gives the clear priority would lose that event and read the bit back as 0. It also writes end-of-interrupt while sources are still pending: a design that does not clear the handshake bit when it fires would leave `smi_n` high for a cycle, or fail to re-raise it afterwards. Writes of all ones probe the reserved and write-only bits, which must still read 0. Writes at foreign offsets and sources that are latched but disabled must leave `smi_n` high.

// File: rtl/smi_pkg.sv
package smi_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_SRC = 9;
    localparam logic [ADDR_W-1:0] REG_OFS = 8'h14;
    localparam int EOI_POS = 31;
    localparam int SCI_POS = 30;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Command decoded from one bus write
    typedef struct packed {
        logic     eoi_set;
        logic     sci_req;
        src_vec_t clr;
    } smi_cmd_t;

    // Register bit that carries source i; software decodes these positions
    function automatic int src_pos(input int i);
        case (i)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            3:       return 8;
            4:       return 9;
            5:       return 10;
            6:       return 15;
            7:       return 16;
            8:       return 17;
            default: return 0;
        endcase
    endfunction

    // Bits that may read back as nonzero
    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) m[src_pos(i)] = 1'b1;
        m[EOI_POS] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/smi_status_bits.sv
module smi_status_bits
    import smi_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           stat_o[g] <= 1'b0;
            else if (set_i[g]) stat_o[g] <= 1'b1;   // set wins over clear
            else if (clr_i[g]) stat_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/smi_handshake.sv
module smi_handshake (
    input  logic clk,
    input  logic rst,
    input  logic pend_i,
    input  logic eoi_set_i,
    input  logic sci_req_i,
    output logic eoi_o,
    output logic smi_n_o,
    output logic sci_o
);

    logic fire;
    assign fire = eoi_o & pend_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            eoi_o   <= 1'b0;
            smi_n_o <= 1'b1;
            sci_o   <= 1'b0;
        end else begin
            sci_o <= sci_req_i;
            if (fire) begin
                eoi_o   <= 1'b0;
                smi_n_o <= 1'b0;
            end else if (eoi_set_i) begin
                eoi_o   <= 1'b1;
                smi_n_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/smi_regmap.sv
module smi_regmap
    import smi_pkg::*;
#(
    parameter int                AW  = ADDR_W,
    parameter logic [AW-1:0]     OFS = REG_OFS
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  src_vec_t         stat_i,
    input  logic             eoi_i,
    output smi_cmd_t         cmd_o,
    output logic [REG_W-1:0] rdata_o
);

    logic hit;
    assign hit = (addr_i == OFS);

    always_comb begin
        cmd_o = '0;
        if (hit && wr_i) begin
            cmd_o.eoi_set = wdata_i[EOI_POS];
            cmd_o.sci_req = wdata_i[SCI_POS];
            for (int i = 0; i < NUM_SRC; i++) cmd_o.clr[i] = wdata_i[src_pos(i)];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit) begin
            rdata_o[EOI_POS] = eoi_i;
            for (int i = 0; i < NUM_SRC; i++) rdata_o[src_pos(i)] = stat_i[i];
        end
    end

endmodule

// File: rtl/smi_status_ctrl.sv
module smi_status_ctrl
    import smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_SRC-1:0] src_en,
    output logic              smi_n,
    output logic              sci_pulse
);

    smi_cmd_t cmd;
    src_vec_t stat_q;
    logic     eoi_q;
    logic     pend;

    smi_regmap #(.AW(ADDR_W), .OFS(REG_OFS)) u_map (
        .addr_i (bus_addr),
        .wr_i   (bus_wr),
        .wdata_i(bus_wdata),
        .stat_i (stat_q),
        .eoi_i  (eoi_q),
        .cmd_o  (cmd),
        .rdata_o(bus_rdata)
    );

    smi_status_bits #(.N(NUM_SRC)) u_bits (
        .clk   (clk),
        .rst   (rst),
        .set_i (src_evt),
        .clr_i (cmd.clr),
        .stat_o(stat_q)
    );

    assign pend = |(stat_q & src_en);

    smi_handshake u_hs (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (pend),
        .eoi_set_i(cmd.eoi_set),
        .sci_req_i(cmd.sci_req),
        .eoi_o    (eoi_q),
        .smi_n_o  (smi_n),
        .sci_o    (sci_pulse)
    );

endmodule

// File: rtl/smi_status_chk.sv
module smi_status_chk
    import smi_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [REG_W-1:0]   bus_rdata,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [NUM_SRC-1:0] src_en,
    input logic               smi_n,
    input logic               sci_pulse
);

    logic wr_hit;
    assign wr_hit = bus_wr && (bus_addr == REG_OFS);

    // R6
    sci_origin_chk: assert property (@(posedge clk) disable iff (rst)
        sci_pulse |-> $past(wr_hit && bus_wdata[SCI_POS]));

    // R5
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~live_mask()) == '0);

    // R8
    smi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smi_n && !(wr_hit && bus_wdata[EOI_POS])) |=> !smi_n);

    // R7
    eoi_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!smi_n && bus_addr == REG_OFS) |-> !bus_rdata[EOI_POS]);

    // R7
    fire_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_OFS && bus_rdata[EOI_POS] &&
         |(src_en & {bus_rdata[17:15], bus_rdata[10:8], bus_rdata[4:2]}))
        |=> !smi_n);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // R2
        evt_set_chk: assert property (@(posedge clk) disable iff (rst)
            (src_evt[g] && bus_addr == REG_OFS) |=> (bus_addr != REG_OFS || bus_rdata[src_pos(g)]));
        // R3
        clr_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && bus_wdata[src_pos(g)] && !src_evt[g]) |=>
            (bus_addr != REG_OFS || !bus_rdata[src_pos(g)]));
    end

endmodule

bind smi_status_ctrl smi_status_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_evt  (src_evt),
    .src_en   (src_en),
    .smi_n    (smi_n),
    .sci_pulse(sci_pulse)
);

// File: tb/smi_status_ctrl_bench.sv
module smi_status_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OFS = 8'h14;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [8:0]  src_evt;
    logic [8:0]  src_en;
    logic        smi_n;
    logic        sci_pulse;

    int checks = 0;
    int errors = 0;

    // Bench model
    logic [8:0] m_stat;
    logic       m_eoi;
    logic       m_smi_n;
    logic       m_sci;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_status_ctrl u_smi_status_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
        .src_en(src_en), .smi_n(smi_n), .sci_pulse(sci_pulse)
    );

    function automatic logic [31:0] pack_reg(input logic [8:0] s, input logic e);
        logic [31:0] r;
        r = '0;
        r[2] = s[0]; r[3] = s[1]; r[4] = s[2];
        r[8] = s[3]; r[9] = s[4]; r[10] = s[5];
        r[15] = s[6]; r[16] = s[7]; r[17] = s[8];
        r[31] = e;
        return r;
    endfunction

    function automatic logic [8:0] unpack_src(input logic [31:0] d);
        return {d[17], d[16], d[15], d[10], d[9], d[8], d[4], d[3], d[2]};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock with the given stimulus, then compare outputs and readback
    task automatic cycle(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                         input logic [8:0] evt, input logic [8:0] en, input string tag);
        logic hit, fire;
        @(negedge clk);
        bus_wr = wr; bus_addr = addr; bus_wdata = data; src_evt = evt; src_en = en;
        hit  = wr && (addr == OFS);
        fire = m_eoi && |(m_stat & en);
        m_stat  = (m_stat & ~(hit ? unpack_src(data) : 9'h0)) | evt;
        m_sci   = hit && data[30];
        if (fire) begin
            m_eoi = 1'b0; m_smi_n = 1'b0;
        end else if (hit && data[31]) begin
            m_eoi = 1'b1; m_smi_n = 1'b1;
        end
        @(posedge clk);
        #1;
        check(tag, "smi_n", {31'h0, smi_n}, {31'h0, m_smi_n});
        check(tag, "sci_pulse", {31'h0, sci_pulse}, {31'h0, m_sci});
        bus_wr = 1'b0; src_evt = '0; bus_addr = OFS;
        #1;
        check(tag, "rdata", bus_rdata, pack_reg(m_stat, m_eoi));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; bus_addr = OFS; bus_wr = 1'b0; bus_wdata = '0;
        src_evt = '0; src_en = '0;
        m_stat = '0; m_eoi = 1'b0; m_smi_n = 1'b1; m_sci = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "rdata", bus_rdata, 32'h0);
        check("R1", "smi_n", {31'h0, smi_n}, 32'h1);
        check("R1", "sci_pulse", {31'h0, sci_pulse}, 32'h0);

        // R2 each source sets its own bit
        for (int i = 0; i < 9; i++) cycle(1'b0, OFS, 32'h0, 9'(1 << i), 9'h0, "R2");
        // R11 pending and enabled, handshake bit still 0: no interrupt
        cycle(1'b0, OFS, 32'h0, 9'h0, 9'h1FF, "R11");
        cycle(1'b0, OFS, 32'h0, 9'h0, 9'h1FF, "R11");
        // R3 write 1 clears APM bit 4, write 0 changes nothing
        cycle(1'b1, OFS, 32'h0000_0010, 9'h0, 9'h0, "R3");
        cycle(1'b1, OFS, 32'h0, 9'h0, 9'h0, "R3");
        // R9 handshake set, all disabled: stays high
        cycle(1'b1, OFS, 32'h8000_0000, 9'h0, 9'h0, "R9");
        cycle(1'b0, OFS, 32'h0, 9'h0, 9'h0, "R9");
        cycle(1'b0, OFS, 32'h0, 9'h0, 9'h004, "R9");
        // R7 enable a latched source: fires, handshake clears
        cycle(1'b0, OFS, 32'h0, 9'h0, 9'h100, "R7");
        // R8 stays low through events and status clears
        cycle(1'b0, OFS, 32'h0, 9'h0A5, 9'h100, "R8");
        cycle(1'b1, OFS, 32'h0002_0000, 9'h0, 9'h100, "R8");
        cycle(1'b0, OFS, 32'h0, 9'h0, 9'h1FF, "R8");
        // R8 release; still pending, so next edge fires again (R7)
        cycle(1'b1, OFS, 32'h8000_0000, 9'h0, 9'h1FF, "R8");
        cycle(1'b0, OFS, 32'h0, 9'h0, 9'h1FF, "R7");
        // R10 foreign offset write ignored, foreign read returns 0
        cycle(1'b1, 8'h10, 32'hFFFF_FFFF, 9'h0, 9'h0, "R10");
        @(negedge clk);
        bus_addr = 8'h18;
        #1;
        check("R10", "foreign rdata", bus_rdata, 32'h0);
        // R6 SCI pulse only for one cycle
        cycle(1'b1, OFS, 32'h4000_0000, 9'h0, 9'h0, "R6");
        cycle(1'b0, OFS, 32'h0, 9'h0, 9'h0, "R6");
        // R4 set and clear collide on bit 17
        cycle(1'b1, OFS, 32'h0002_0000, 9'h100, 9'h0, "R4");
        // R5 all ones: reserved and write-only bits read 0
        cycle(1'b1, OFS, 32'hFFFF_FFFF, 9'h0, 9'h0, "R5");
        cycle(1'b1, OFS, 32'h7FFC_78E3, 9'h0, 9'h0, "R5");

        // Constrained random traffic
        for (int n = 0; n < 800; n++) begin
            logic        w;
            logic [7:0]  a;
            logic [31:0] d;
            logic [8:0]  e, en;
            w  = ($urandom_range(3) == 0);
            a  = ($urandom_range(7) == 0) ? 8'($urandom) : OFS;
            d  = $urandom;
            if ($urandom_range(1) == 0) d[30] = 1'b0;
            e  = ($urandom_range(2) == 0) ? 9'(1 << $urandom_range(8)) : 9'h0;
            en = 9'($urandom);
            cycle(w, a, d, e, en, "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule